// File: doc/BRIEF.md
# I2C SCL Period Generator

This block times the serial clock of an I2C master. A coarse prescaler divides the peripheral clock by one to four to form an internal tick. A phase timer then counts those ticks through a low phase and a high phase. The full SCL period is 20 + 8·STEP + RISE_CYC internal ticks. STEP is a programmable step value. RISE_CYC is a fixed synthesis-time allowance for the line's fall time, rise time and internal delay. With a 20 MHz internal clock, about 285 ns rounds up to 6 ticks.

Both settings come from one clock-configuration word. The prescaler field sits in bits [1:0] and the step field starts at bit 2, so a driver writes `(step << 2) | div`. The bit engine reads two phase enables and two one-cycle strobes. It uses them to drive or release SCL and to place data changes and samples.

The word is captured only when a new period begins. The high phase counts only while the sensed SCL line is high, so a slave that holds SCL low stretches the high phase. The sense input is taken as already synchronous to the peripheral clock.

Top module: `scl_clkgen`

## Requirements
- R1: Bits [1:0] of `clk_cfg_i` (DIV) make the internal tick advance once every DIV+1 peripheral cycles, so every phase length scales by DIV+1.
- R2: With no stretching, consecutive `fall_tick_o` strobes are (DIV+1)·(20 + 8·STEP + RISE_CYC) peripheral cycles apart. STEP is `clk_cfg_i[STEP_W+1:2]`.
- R3: With P = 20 + 8·STEP + RISE_CYC, the low phase lasts (DIV+1)·(P − ⌊P/2⌋) cycles and the high phase lasts (DIV+1)·⌊P/2⌋ cycles. `scl_low_en_o` and `scl_high_en_o` follow these phases.
- R4: During the high phase, cycles with `scl_sense_i` low are not counted. Each such cycle lengthens the high phase, and the period, by one cycle.
- R5: A new configuration word is captured only in the cycle a period begins. The period in progress keeps the old DIV and STEP.
- R6: `fall_tick_o` is high for exactly the first cycle of each low phase. `rise_tick_o` is high for exactly the first cycle of each high phase.
- R7: When `run_i` is high while idle, the low phase begins at the next clock edge, with `fall_tick_o` set.
- R8: When `run_i` is low at a clock edge, the block is idle after that edge: both enables and both strobes are 0.
- R9: During and right after reset, all four outputs are 0.
- R10: `scl_low_en_o` and `scl_high_en_o` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Peripheral clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| run_i | input | 1 | Run SCL timing while high; idle when low |
| clk_cfg_i | input | STEP_W+2 | Configuration word: DIV in [1:0], STEP above it |
| scl_sense_i | input | 1 | Sensed level of the SCL line, synchronous |
| scl_low_en_o | output | 1 | Low phase active: drive SCL low |
| scl_high_en_o | output | 1 | High phase active: SCL released |
| fall_tick_o | output | 1 | Strobe in the first cycle of a low phase |
| rise_tick_o | output | 1 | Strobe in the first cycle of a high phase |

## Verification
Two things can land on the same clock edge: the end of a high phase and a rewrite of the configuration word. The bench changes the word in the middle of a period. It then checks that the measured period follows the old setting and that the next period follows the new one.

A pause from a stretched SCL can also overlap the prescaler count when DIV is nonzero. The bench holds the sense line low partway through a divided high phase. It expects the period to grow by exactly the number of held cycles.

A cycle-level reference model in the bench is compared against all four outputs on every clock.

// File: rtl/scl_clkgen_pkg.sv
package scl_clkgen_pkg;

    localparam int DIV_W     = 2;   // prescaler field width
    localparam int BASE_CYC  = 20;  // fixed part of every period
    localparam int STEP_SHL  = 3;   // each step adds 8 ticks

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOW  = 2'd1,
        PH_HIGH = 2'd2
    } scl_phase_e;

endpackage

// File: rtl/scl_prescaler.sv
module scl_prescaler
    import scl_clkgen_pkg::*;
#(
    parameter int PDIV_W = DIV_W
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              clr_i,
    input  logic              run_i,
    input  logic [PDIV_W-1:0] div_i,
    output logic              tick_o
);

    typedef struct packed {
        logic [PDIV_W-1:0] cnt;
    } pre_st_t;

    pre_st_t st_d, st_q;
    logic    wrap;

    assign wrap   = (st_q.cnt == div_i);
    assign tick_o = run_i && !clr_i && wrap;

    always_comb begin
        st_d = st_q;
        if (clr_i) begin
            st_d.cnt = '0;
        end else if (run_i) begin
            st_d.cnt = wrap ? '0 : st_q.cnt + PDIV_W'(1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/scl_phase_timer.sv
module scl_phase_timer
    import scl_clkgen_pkg::*;
#(
    parameter int CNT_W = 10
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             run_i,
    input  logic             tick_i,
    input  logic [CNT_W-1:0] low_len_i,
    input  logic [CNT_W-1:0] high_len_i,
    output scl_phase_e       phase_o,
    output logic             fall_o,
    output logic             rise_o,
    output logic             boundary_o
);

    typedef struct packed {
        scl_phase_e       phase;
        logic [CNT_W-1:0] cnt;
        logic             fall;
        logic             rise;
    } tmr_st_t;

    tmr_st_t st_d, st_q;
    logic    low_last, high_last;

    assign low_last  = (st_q.cnt == low_len_i  - CNT_W'(1));
    assign high_last = (st_q.cnt == high_len_i - CNT_W'(1));

    always_comb begin
        st_d       = st_q;
        st_d.fall  = 1'b0;
        st_d.rise  = 1'b0;
        boundary_o = 1'b0;
        unique case (st_q.phase)
            PH_IDLE: begin
                if (run_i) begin
                    st_d.phase = PH_LOW;
                    st_d.cnt   = '0;
                    st_d.fall  = 1'b1;
                    boundary_o = 1'b1;
                end
            end
            PH_LOW: begin
                if (!run_i) begin
                    st_d.phase = PH_IDLE;
                    st_d.cnt   = '0;
                end else if (tick_i) begin
                    if (low_last) begin
                        st_d.phase = PH_HIGH;
                        st_d.cnt   = '0;
                        st_d.rise  = 1'b1;
                    end else begin
                        st_d.cnt = st_q.cnt + CNT_W'(1);
                    end
                end
            end
            PH_HIGH: begin
                if (!run_i) begin
                    st_d.phase = PH_IDLE;
                    st_d.cnt   = '0;
                end else if (tick_i) begin
                    if (high_last) begin
                        st_d.phase = PH_LOW;
                        st_d.cnt   = '0;
                        st_d.fall  = 1'b1;
                        boundary_o = 1'b1;
                    end else begin
                        st_d.cnt = st_q.cnt + CNT_W'(1);
                    end
                end
            end
            default: begin
                st_d.phase = PH_IDLE;
                st_d.cnt   = '0;
            end
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '{phase: PH_IDLE, cnt: '0, fall: 1'b0, rise: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign phase_o = st_q.phase;
    assign fall_o  = st_q.fall;
    assign rise_o  = st_q.rise;

endmodule

// File: rtl/scl_clkgen.sv
module scl_clkgen
    import scl_clkgen_pkg::*;
#(
    parameter int STEP_W   = 6,
    parameter int RISE_CYC = 6
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              run_i,
    input  logic [STEP_W+1:0] clk_cfg_i,
    input  logic              scl_sense_i,
    output logic              scl_low_en_o,
    output logic              scl_high_en_o,
    output logic              fall_tick_o,
    output logic              rise_tick_o
);

    localparam int CFG_W   = STEP_W + DIV_W;
    localparam int MAX_PER = BASE_CYC + (((1 << STEP_W) - 1) << STEP_SHL) + RISE_CYC;
    localparam int CNT_W   = $clog2(MAX_PER + 1);

    typedef struct packed {
        logic [CFG_W-1:0] cfg;
    } top_st_t;

    top_st_t          st_d, st_q;
    logic [CFG_W-1:0] cfg_act;
    logic [DIV_W-1:0] div;
    logic [STEP_W-1:0] step;
    logic [CNT_W-1:0] period, low_len, high_len;
    scl_phase_e       phase;
    logic             ick, boundary, pre_clr, pre_run;

    assign cfg_act = st_q.cfg;
    assign div     = cfg_act[DIV_W-1:0];
    assign step    = cfg_act[CFG_W-1:DIV_W];

    // period in internal ticks; low half takes the odd tick
    assign period   = CNT_W'(BASE_CYC) + (CNT_W'(step) << STEP_SHL) + CNT_W'(RISE_CYC);
    assign high_len = period >> 1;
    assign low_len  = period - high_len;

    // high phase pauses while the line is still held low
    assign pre_clr = (phase == PH_IDLE);
    assign pre_run = (phase == PH_LOW) || ((phase == PH_HIGH) && scl_sense_i);

    scl_prescaler #(
        .PDIV_W (DIV_W)
    ) u_pre (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .clr_i  (pre_clr),
        .run_i  (pre_run),
        .div_i  (div),
        .tick_o (ick)
    );

    scl_phase_timer #(
        .CNT_W (CNT_W)
    ) u_tmr (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .run_i      (run_i),
        .tick_i     (ick),
        .low_len_i  (low_len),
        .high_len_i (high_len),
        .phase_o    (phase),
        .fall_o     (fall_tick_o),
        .rise_o     (rise_tick_o),
        .boundary_o (boundary)
    );

    // configuration word is sampled only as a period opens
    always_comb begin
        st_d = st_q;
        if (boundary) begin
            st_d.cfg = clk_cfg_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign scl_low_en_o  = (phase == PH_LOW);
    assign scl_high_en_o = (phase == PH_HIGH);

endmodule

// File: rtl/scl_clkgen_chk.sv
module scl_clkgen_chk #(
    parameter int CFG_W = 8
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             run_i,
    input logic             scl_sense_i,
    input logic             scl_low_en_o,
    input logic             scl_high_en_o,
    input logic             fall_tick_o,
    input logic             rise_tick_o,
    input logic [CFG_W-1:0] cfg_act
);

    // R10
    a_r10_phase_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(scl_low_en_o && scl_high_en_o));

    // R6
    a_r6_fall_opens_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fall_tick_o |-> (scl_low_en_o && !$past(scl_low_en_o)));

    // R6
    a_r6_rise_opens_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rise_tick_o |-> (scl_high_en_o && !$past(scl_high_en_o)));

    // R7
    a_r7_start_from_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (run_i && !scl_low_en_o && !scl_high_en_o) |=> (fall_tick_o && scl_low_en_o));

    // R8
    a_r8_stop_to_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !run_i |=> (!scl_low_en_o && !scl_high_en_o && !fall_tick_o && !rise_tick_o));

    // R4
    a_r4_hold_while_stretched: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (run_i && scl_high_en_o && !scl_sense_i) |=> scl_high_en_o);

    // R5
    a_r5_cfg_only_at_boundary: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !fall_tick_o |-> $stable(cfg_act));

    // R9
    always @(posedge clk_i) begin
        if (!rst_ni) begin
            a_r9_reset_quiet: assert (!scl_low_en_o && !scl_high_en_o && !fall_tick_o && !rise_tick_o);
        end
    end

endmodule

bind scl_clkgen scl_clkgen_chk #(
    .CFG_W (STEP_W + 2)
) chk_i (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .run_i         (run_i),
    .scl_sense_i   (scl_sense_i),
    .scl_low_en_o  (scl_low_en_o),
    .scl_high_en_o (scl_high_en_o),
    .fall_tick_o   (fall_tick_o),
    .rise_tick_o   (rise_tick_o),
    .cfg_act       (cfg_act)
);

// File: tb/scl_clkgen_tb.sv
module scl_clkgen_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int STEP_W     = 6;
    localparam int RISE       = 6;
    localparam int CFG_W      = STEP_W + 2;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             en_r = 1'b0;
    logic [CFG_W-1:0] cfg_r = '0;
    logic             stretch_r = 1'b0;
    logic             scl_line;
    logic             low_en, high_en, fall_t, rise_t;

    int errors = 0;
    int checks = 0;
    int cyc    = 0;

    // reference model state
    int m_ph   = 0;  // 0 idle, 1 low, 2 high
    int m_left = 0;
    int m_cfg  = 0;
    bit m_fall = 0;
    bit m_rise = 0;

    // period measurement
    bit have_prev = 0;
    int meas_cfg  = 0;
    int meas_start = 0;
    int stretch_cnt = 0;
    bit cfg_moved = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign scl_line = !(stretch_r || low_en);

    scl_clkgen #(.STEP_W(STEP_W), .RISE_CYC(RISE)) dut_i (
        .clk_i         (clk),
        .rst_ni        (rst_n),
        .run_i         (en_r),
        .clk_cfg_i     (cfg_r),
        .scl_sense_i   (scl_line),
        .scl_low_en_o  (low_en),
        .scl_high_en_o (high_en),
        .fall_tick_o   (fall_t),
        .rise_tick_o   (rise_t)
    );

    function automatic int f_div(int c);   return (c & 3) + 1; endfunction
    function automatic int f_per(int c);   return 20 + 8 * (c >> 2) + RISE; endfunction
    function automatic int f_high(int c);  return f_per(c) / 2; endfunction
    function automatic int f_low(int c);   return f_per(c) - f_per(c) / 2; endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s at cycle %0d: actual=%0d expected=%0d", tag, cyc, act, exp);
        end
    endtask

    task automatic model_step(input bit en, input int cfg, input bit scl);
        m_fall = 0;
        m_rise = 0;
        if (!en) begin
            m_ph = 0;
        end else begin
            case (m_ph)
                0: begin
                    m_ph = 1; m_cfg = cfg; m_fall = 1;
                    m_left = f_div(m_cfg) * f_low(m_cfg);
                end
                1: begin
                    m_left--;
                    if (m_left == 0) begin
                        m_ph = 2; m_rise = 1;
                        m_left = f_div(m_cfg) * f_high(m_cfg);
                    end
                end
                default: begin
                    if (scl) begin
                        m_left--;
                        if (m_left == 0) begin
                            m_ph = 1; m_cfg = cfg; m_fall = 1;
                            m_left = f_div(m_cfg) * f_low(m_cfg);
                        end
                    end
                end
            endcase
        end
    endtask

    task automatic compare();
        int exp_low, exp_high, tot;
        string tag;
        exp_low  = (m_ph == 1) ? 1 : 0;
        exp_high = (m_ph == 2) ? 1 : 0;
        check(low_en == exp_low[0] && high_en == exp_high[0], "R3 phase enables",
              {low_en, high_en}, {exp_low[0], exp_high[0]});
        check(fall_t == m_fall && rise_t == m_rise, "R6 strobes",
              {fall_t, rise_t}, {m_fall, m_rise});
        check(!(low_en && high_en), "R10 exclusive enables", {low_en, high_en}, 0);
        if (!low_en && !high_en) have_prev = 0;
        if (rise_t && have_prev) begin
            check(cyc - meas_start == f_div(meas_cfg) * f_low(meas_cfg), "R3 low duration",
                  cyc - meas_start, f_div(meas_cfg) * f_low(meas_cfg));
        end
        if (fall_t) begin
            if (have_prev) begin
                tot = f_div(meas_cfg) * f_per(meas_cfg) + stretch_cnt;
                if (stretch_cnt > 0)       tag = "R4 stretched period";
                else if (cfg_moved)        tag = "R5 period keeps old config";
                else if ((meas_cfg & 3) != 0) tag = "R1 divided period";
                else                       tag = "R2 period";
                check(cyc - meas_start == tot, tag, cyc - meas_start, tot);
            end
            have_prev   = 1;
            meas_cfg    = m_cfg;
            meas_start  = cyc;
            stretch_cnt = 0;
            cfg_moved   = 0;
        end
    endtask

    task automatic step();
        if (m_ph == 2 && en_r && !scl_line) stretch_cnt++;
        if (have_prev && int'(cfg_r) != meas_cfg) cfg_moved = 1;
        model_step(en_r, int'(cfg_r), scl_line);
        @(negedge clk);
        cyc++;
        compare();
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic wait_high(input int limit);
        for (int i = 0; i < limit && !high_en; i++) step();
    endtask

    task automatic wait_low(input int limit);
        for (int i = 0; i < limit && !low_en; i++) step();
    endtask

    initial begin
        repeat (4) @(negedge clk);
        check(!low_en && !high_en && !fall_t && !rise_t, "R9 reset outputs",
              {low_en, high_en, fall_t, rise_t}, 0);
        rst_n = 1'b1;
        run(3);
        check(!low_en && !high_en, "R9 idle after reset", {low_en, high_en}, 0);

        // start, no division, step 0: 26 ticks
        cfg_r = CFG_W'((0 << 2) | 0);
        en_r  = 1'b1;
        step();
        check(low_en && fall_t, "R7 low phase starts next edge", {low_en, fall_t}, 3);
        run(3 * 26 + 5);

        // change config in the middle of a low phase
        wait_low(200);
        run(4);
        cfg_r = CFG_W'((2 << 2) | 1);
        run(4 * 84 + 30);

        // coarse division by four
        cfg_r = CFG_W'((5 << 2) | 3);
        run(3 * 264 + 300);

        // stretched high phase with division by three
        cfg_r = CFG_W'((1 << 2) | 2);
        run(2 * 102 + 120);
        wait_high(200);
        run(10);
        stretch_r = 1'b1;
        run(7);
        stretch_r = 1'b0;
        run(2 * 102 + 20);

        // drop run in the middle of a high phase
        wait_high(200);
        run(5);
        en_r = 1'b0;
        step();
        check(!low_en && !high_en && !fall_t && !rise_t, "R8 idle after run drops",
              {low_en, high_en, fall_t, rise_t}, 0);
        run(5);
        check(!low_en && !high_en, "R8 stays idle", {low_en, high_en}, 0);

        // restart with the largest step value
        cfg_r = CFG_W'((63 << 2) | 0);
        en_r  = 1'b1;
        step();
        check(low_en && fall_t, "R7 restart", {low_en, fall_t}, 3);
        run(2 * 530 + 10);

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired at cycle %0d: actual=hung expected=done", cyc);
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule